// File: doc/BRIEF.md
# Clear-on-read interrupt status register

This block collects event pulses from the receiver, transmitter and loop logic of a serial link controller into an eight-bit status word. A host reads the word, and the read clears it. A host-written mask selects which pending bits may raise the active-high interrupt output. The global summary bit repeats that interrupt condition, so a host polling several such blocks can find the one that is asking for service.

The meaning of two bit positions depends on whether the controller runs in loop mode. A visibility control lets masked events still latch, so the host can see them, while keeping them away from the interrupt output and the summary bit. When the transmit-ready interrupt is taken through its vector, a separate acknowledge strobe clears that one bit without a full read.

Top module: `irq_status_reg`

## Requirements
- R1: After reset the status word reads 0x00, the mask is all ones (every source masked) and irq_o and glob_o are low.
- R2: An admitted event pulse sets its status bit on the next clock edge, at these positions: bit 0 tx ready, bit 1 tx repeat, bit 2 status change, bit 3 timer, bit 4 tx underrun, bit 5 all-sent or active-on-loop, bit 6 rx overflow or on-loop, bit 7 end-of-poll. Without a read or acknowledge, a set bit stays set.
- R3: stat_o always shows the register contents. A clock edge with rd_i high clears every bit.
- R4: An admitted event that arrives in the same cycle as a read or acknowledge is left set after that edge.
- R5: vec_ack_i high at an edge clears only bit 0. The other bits are untouched.
- R6: A mask bit of 1 masks the matching status bit. With vis_all_i low, a masked event is not latched.
- R7: With vis_all_i high, a masked event is latched and readable, but it does not drive irq_o or glob_o.
- R8: irq_o is high exactly when some status bit is set whose mask bit is 0. glob_o always equals irq_o.
- R9: With loop_mode_i high, bit 6 latches on-loop and bit 5 latches active-on-loop. With it low, bit 6 latches rx overflow and bit 5 latches all-sent. The event inputs not selected for the current mode have no effect.
- R10: The end-of-poll event (bit 7) is latched only while loop_mode_i is high.
- R11: mask_we_i high at an edge loads mask_wdata_i. From the next cycle the new mask decides irq_o for the bits that are already pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| loop_mode_i | input | 1 | Loop mode select for bits 7, 6 and 5 |
| vis_all_i | input | 1 | Latch masked events as well |
| mask_we_i | input | 1 | Mask write strobe |
| mask_wdata_i | input | 8 | New mask value, 1 = masked |
| rd_i | input | 1 | Host read strobe; clears the word at the edge |
| vec_ack_i | input | 1 | Vector-issued strobe for the tx ready bit |
| ev_end_poll_i | input | 1 | End-of-poll event |
| ev_on_loop_i | input | 1 | On-loop event |
| ev_rx_ovf_i | input | 1 | Receive overflow event |
| ev_act_loop_i | input | 1 | Active-on-loop event |
| ev_all_sent_i | input | 1 | All-sent event |
| ev_tx_undr_i | input | 1 | Transmit underrun or extended transmission end |
| ev_timer_i | input | 1 | Timer event |
| ev_stat_chg_i | input | 1 | Carrier or status change event |
| ev_tx_rpt_i | input | 1 | Transmit message repeat event |
| ev_tx_rdy_i | input | 1 | Transmit pool ready event |
| stat_o | output | 8 | Status word |
| irq_o | output | 1 | Interrupt, active high |
| glob_o | output | 1 | Global status summary bit |

## Verification
Every output comes straight from registered state, so a wrong latch, clear or mask decision shows on stat_o or irq_o in the first cycle after the edge that caused it. The bench compares all three outputs against a behavioural model on every clock, which catches such a fault in that same cycle. Directed sequences cover the cases that random stimulus rarely hits: an event coinciding with a read, an event coinciding with an acknowledge, a mode swap between pulses, and a mask rewrite over bits that are already pending.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;
  localparam int NBITS = 8;
  localparam int B_TX_RDY   = 0;
  localparam int B_TX_RPT   = 1;
  localparam int B_STAT_CHG = 2;
  localparam int B_TIMER    = 3;
  localparam int B_TX_UNDR  = 4;
  localparam int B_SENT_AOL = 5;
  localparam int B_OVF_OL   = 6;
  localparam int B_END_POLL = 7;

  typedef logic [NBITS-1:0] stat_t;

  typedef struct packed {
    logic end_poll;
    logic on_loop;
    logic rx_ovf;
    logic act_loop;
    logic all_sent;
    logic tx_undr;
    logic timer;
    logic stat_chg;
    logic tx_rpt;
    logic tx_rdy;
  } raw_ev_t;
endpackage

// File: rtl/irq_evt_sel.sv
module irq_evt_sel
  import irq_stat_pkg::*;
(
  input  logic    loop_mode_i,
  input  raw_ev_t raw_i,
  output stat_t   ev_o
);
  always_comb begin
    ev_o             = '0;
    ev_o[B_TX_RDY]   = raw_i.tx_rdy;
    ev_o[B_TX_RPT]   = raw_i.tx_rpt;
    ev_o[B_STAT_CHG] = raw_i.stat_chg;
    ev_o[B_TIMER]    = raw_i.timer;
    ev_o[B_TX_UNDR]  = raw_i.tx_undr;
    // mode-dependent positions
    ev_o[B_SENT_AOL] = loop_mode_i ? raw_i.act_loop : raw_i.all_sent;
    ev_o[B_OVF_OL]   = loop_mode_i ? raw_i.on_loop  : raw_i.rx_ovf;
    ev_o[B_END_POLL] = loop_mode_i & raw_i.end_poll;
  end
endmodule

// File: rtl/irq_stat_cell.sv
module irq_stat_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  // set wins over clear: no event lost on a coinciding read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= 1'b0;
    else if (set_i)  q_o <= 1'b1;
    else if (clr_i)  q_o <= 1'b0;
  end
endmodule

// File: rtl/irq_summary.sv
module irq_summary #(
  parameter int W = 8
) (
  input  logic [W-1:0] stat_i,
  input  logic [W-1:0] mask_i,
  output logic         irq_o,
  output logic         glob_o
);
  logic any_w;
  assign any_w  = |(stat_i & ~mask_i);
  assign irq_o  = any_w;
  assign glob_o = any_w;
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg
  import irq_stat_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             loop_mode_i,
  input  logic             vis_all_i,
  input  logic             mask_we_i,
  input  logic [NBITS-1:0] mask_wdata_i,
  input  logic             rd_i,
  input  logic             vec_ack_i,
  input  logic             ev_end_poll_i,
  input  logic             ev_on_loop_i,
  input  logic             ev_rx_ovf_i,
  input  logic             ev_act_loop_i,
  input  logic             ev_all_sent_i,
  input  logic             ev_tx_undr_i,
  input  logic             ev_timer_i,
  input  logic             ev_stat_chg_i,
  input  logic             ev_tx_rpt_i,
  input  logic             ev_tx_rdy_i,
  output logic [NBITS-1:0] stat_o,
  output logic             irq_o,
  output logic             glob_o
);
  raw_ev_t raw_w;
  stat_t   ev_w;
  stat_t   admit_w;
  stat_t   clr_w;
  stat_t   stat_q;
  stat_t   mask_q;

  assign raw_w = '{end_poll: ev_end_poll_i, on_loop: ev_on_loop_i,
                   rx_ovf: ev_rx_ovf_i, act_loop: ev_act_loop_i,
                   all_sent: ev_all_sent_i, tx_undr: ev_tx_undr_i,
                   timer: ev_timer_i, stat_chg: ev_stat_chg_i,
                   tx_rpt: ev_tx_rpt_i, tx_rdy: ev_tx_rdy_i};

  irq_evt_sel u_sel (
    .loop_mode_i (loop_mode_i),
    .raw_i       (raw_w),
    .ev_o        (ev_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mask_q <= '1;
    else if (mask_we_i) mask_q <= mask_wdata_i;
  end

  assign admit_w = ~mask_q | {NBITS{vis_all_i}};

  for (genvar b = 0; b < NBITS; b++) begin : g_bit
    if (b == B_TX_RDY) begin : g_ack
      assign clr_w[b] = rd_i | vec_ack_i;
    end else begin : g_rd
      assign clr_w[b] = rd_i;
    end
    irq_stat_cell u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (ev_w[b] & admit_w[b]),
      .clr_i  (clr_w[b]),
      .q_o    (stat_q[b])
    );
  end

  irq_summary #(.W(NBITS)) u_sum (
    .stat_i (stat_q),
    .mask_i (mask_q),
    .irq_o  (irq_o),
    .glob_o (glob_o)
  );

  assign stat_o = stat_q;
endmodule

// File: rtl/irq_status_chk.sv
module irq_status_chk
  import irq_stat_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             loop_mode_i,
  input logic             vis_all_i,
  input logic             rd_i,
  input logic             vec_ack_i,
  input logic             ev_end_poll_i,
  input logic             ev_timer_i,
  input logic             ev_on_loop_i,
  input logic             ev_rx_ovf_i,
  input logic             ev_act_loop_i,
  input logic             ev_all_sent_i,
  input logic             ev_tx_undr_i,
  input logic             ev_stat_chg_i,
  input logic             ev_tx_rpt_i,
  input logic             ev_tx_rdy_i,
  input logic [NBITS-1:0] mask_q,
  input logic [NBITS-1:0] stat_o,
  input logic             irq_o,
  input logic             glob_o
);
  logic any_ev;
  assign any_ev = ev_end_poll_i | ev_timer_i | ev_on_loop_i | ev_rx_ovf_i |
                  ev_act_loop_i | ev_all_sent_i | ev_tx_undr_i |
                  ev_stat_chg_i | ev_tx_rpt_i | ev_tx_rdy_i;

  assert_read_clears_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !any_ev) |=> (stat_o == '0));

  assert_sticky_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_i && !vec_ack_i) |=> ((stat_o & $past(stat_o)) == $past(stat_o)));

  assert_event_kept_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_timer_i && (!mask_q[B_TIMER] || vis_all_i)) |=> stat_o[B_TIMER]);

  assert_ack_bit0_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_ack_i && !ev_tx_rdy_i) |=> !stat_o[B_TX_RDY]);

  assert_masked_dropped_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!vis_all_i && mask_q[B_STAT_CHG] && !stat_o[B_STAT_CHG]) |=> !stat_o[B_STAT_CHG]);

  assert_irq_match_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o == |(stat_o & ~mask_q)) && (glob_o == irq_o));

  assert_eop_loop_only_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!loop_mode_i && !stat_o[B_END_POLL]) |=> !stat_o[B_END_POLL]);
endmodule

bind irq_status_reg irq_status_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .loop_mode_i   (loop_mode_i),
  .vis_all_i     (vis_all_i),
  .rd_i          (rd_i),
  .vec_ack_i     (vec_ack_i),
  .ev_end_poll_i (ev_end_poll_i),
  .ev_timer_i    (ev_timer_i),
  .ev_on_loop_i  (ev_on_loop_i),
  .ev_rx_ovf_i   (ev_rx_ovf_i),
  .ev_act_loop_i (ev_act_loop_i),
  .ev_all_sent_i (ev_all_sent_i),
  .ev_tx_undr_i  (ev_tx_undr_i),
  .ev_stat_chg_i (ev_stat_chg_i),
  .ev_tx_rpt_i   (ev_tx_rpt_i),
  .ev_tx_rdy_i   (ev_tx_rdy_i),
  .mask_q        (mask_q),
  .stat_o        (stat_o),
  .irq_o         (irq_o),
  .glob_o        (glob_o)
);

// File: tb/irq_status_reg_test.sv
module irq_status_reg_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic loop_mode = 0, vis_all = 0, mask_we = 0, rd = 0, vec_ack = 0;
  logic [7:0] mask_wdata = '0;
  logic e_eop = 0, e_ol = 0, e_ovf = 0, e_aol = 0, e_sent = 0;
  logic e_undr = 0, e_tim = 0, e_chg = 0, e_rpt = 0, e_rdy = 0;
  logic [7:0] stat;
  logic irq, glob;

  int total = 0, bad = 0;
  bit done = 0;
  bit [7:0] m_stat, m_mask;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_status_reg uut (
    .clk_i(clk), .rst_ni(rst_n), .loop_mode_i(loop_mode), .vis_all_i(vis_all),
    .mask_we_i(mask_we), .mask_wdata_i(mask_wdata), .rd_i(rd), .vec_ack_i(vec_ack),
    .ev_end_poll_i(e_eop), .ev_on_loop_i(e_ol), .ev_rx_ovf_i(e_ovf),
    .ev_act_loop_i(e_aol), .ev_all_sent_i(e_sent), .ev_tx_undr_i(e_undr),
    .ev_timer_i(e_tim), .ev_stat_chg_i(e_chg), .ev_tx_rpt_i(e_rpt), .ev_tx_rdy_i(e_rdy),
    .stat_o(stat), .irq_o(irq), .glob_o(glob)
  );

  // behavioural reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_stat <= 8'h00;
      m_mask <= 8'hFF;
    end else begin
      bit [7:0] evs, nxt;
      evs = {loop_mode && e_eop, loop_mode ? e_ol : e_ovf, loop_mode ? e_aol : e_sent,
             e_undr, e_tim, e_chg, e_rpt, e_rdy};
      nxt = rd ? 8'h00 : m_stat;
      if (vec_ack) nxt[0] = 1'b0;
      for (int i = 0; i < 8; i++)
        if (evs[i] && (!m_mask[i] || vis_all)) nxt[i] = 1'b1;
      m_stat <= nxt;
      if (mask_we) m_mask <= mask_wdata;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      bit exp_irq;
      exp_irq = |(m_stat & ~m_mask);
      total++;
      if (stat !== m_stat || irq !== exp_irq || glob !== exp_irq) begin
        bad++;
        $display("FAIL R8 model compare: stat=%h irq=%b glob=%b expected stat=%h irq=%b",
                 stat, irq, glob, m_stat, exp_irq);
      end
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic clr_in();
    mask_we = 0; rd = 0; vec_ack = 0;
    {e_eop, e_ol, e_ovf, e_aol, e_sent, e_undr, e_tim, e_chg, e_rpt, e_rdy} = '0;
  endtask

  // drive for one edge, then sample after it
  task automatic step();
    tick();
    clr_in();
  endtask

  task automatic wr_mask(input logic [7:0] v);
    mask_we = 1; mask_wdata = v; step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    tick();
    chk("R1 status after reset", stat, 8'h00);
    chk("R1 irq after reset", {7'b0, irq}, 8'h00);
    e_tim = 1; step();
    chk("R1 reset mask blocks timer (R6)", stat, 8'h00);

    wr_mask(8'h00);
    e_tim = 1; step();
    chk("R2 timer at bit 3", stat, 8'h08);
    chk("R8 irq with unmasked pending", {6'b0, glob, irq}, 8'h03);
    rd = 1; step();
    chk("R3 read clears", stat, 8'h00);
    chk("R8 irq low after clear", {7'b0, irq}, 8'h00);

    e_rpt = 1; step();
    rd = 1; e_chg = 1; step();
    chk("R4 event with read kept", stat, 8'h04);
    rd = 1; step();

    e_rdy = 1; step();
    chk("R2 tx ready at bit 0", stat, 8'h01);
    vec_ack = 1; step();
    chk("R5 ack clears bit 0", stat, 8'h00);
    e_rdy = 1; e_rpt = 1; step();
    vec_ack = 1; e_rdy = 1; step();
    chk("R5 ack with event keeps bit 0, bit 1 untouched", stat, 8'h03);
    vec_ack = 1; step();
    chk("R5 ack leaves other bits", stat, 8'h02);
    rd = 1; step();

    wr_mask(8'hF7);
    e_chg = 1; step();
    chk("R6 masked not latched", stat, 8'h00);
    vis_all = 1;
    e_chg = 1; step();
    chk("R7 masked visible", stat, 8'h04);
    chk("R7 no irq for masked", {6'b0, glob, irq}, 8'h00);
    e_tim = 1; step();
    chk("R8 irq from unmasked timer", {6'b0, glob, irq}, 8'h03);
    wr_mask(8'hFF);
    chk("R11 new mask drops irq", {7'b0, irq}, 8'h00);
    chk("R11 status kept", stat, 8'h0C);
    wr_mask(8'hFB);
    chk("R11 unmask pending raises irq", {7'b0, irq}, 8'h01);
    rd = 1; step();
    vis_all = 0;

    wr_mask(8'h00);
    loop_mode = 0;
    e_ovf = 1; e_ol = 1; e_eop = 1; step();
    chk("R9 overflow at bit 6, R10 no end-of-poll", stat, 8'h40);
    e_sent = 1; e_aol = 1; step();
    chk("R9 all-sent at bit 5", stat, 8'h60);
    rd = 1; step();
    loop_mode = 1;
    e_ovf = 1; e_sent = 1; step();
    chk("R9 non-loop events ignored in loop mode", stat, 8'h00);
    e_ol = 1; e_aol = 1; e_eop = 1; step();
    chk("R9 R10 loop events", stat, 8'hE0);
    rd = 1; step();
    loop_mode = 0;
    e_undr = 1; step();
    chk("R2 underrun at bit 4", stat, 8'h10);
    rd = 1; step();

    for (int n = 0; n < 3000; n++) begin
      tick();
      {e_eop, e_ol, e_ovf, e_aol, e_sent, e_undr, e_tim, e_chg, e_rpt, e_rdy} = 10'($urandom);
      rd        = ($urandom % 6) == 0;
      vec_ack   = ($urandom % 5) == 0;
      mask_we   = ($urandom % 12) == 0;
      mask_wdata = 8'($urandom);
      if (($urandom % 40) == 0) loop_mode = ~loop_mode;
      if (($urandom % 30) == 0) vis_all = ~vis_all;
    end
    step();
    tick();

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule